// File: doc/BRIEF.md
# Two-Block Configurable Logic Tile

This block is a very small programmable logic fabric. It holds two logic blocks. Each one is an eight-word by two-bit lookup memory whose three address inputs carry the user's signals. Each of the two data bits is a separate logic function of those three inputs. Either data bit can leave the block straight from the memory, or it can leave through a flip-flop.

Between the two blocks sits a routing stage built from multiplexers. It takes the first block's two outputs and two auxiliary tile inputs. It then picks, for each of its two outputs, one of those four signals. The routed pair drives the low two address bits of the second block. The top address bit of the second block is held at zero.

All configuration is a single 40-bit image: both lookup memories, the four register selects and the two route selects. It is shifted in one bit per clock while the tile is in configuration mode. Once configuration mode is left, the same netlist behaves as the small circuit that the image describes.

Top module: `logic_tile`

## Requirements
- R1: While `cfg_en` is 1, each rising clock edge shifts `cfg_din` into the 40-bit configuration image, most significant bit first. Once all 40 bits have been sent, the first bit sent sits at bit 39. The layout is: bits 39:24 hold the second block's memory, bits 23:8 the first block's memory, bits 7:4 the register selects, bits 3:2 the select for route output 1, and bits 1:0 the select for route output 0. While `cfg_en` is 0 the image does not change.
- R2: Memory word bit `k = addr*2 + d` gives data output `d` for address `addr`. The address of the first block is `usr_in`, where bit 0 is address bit 0.
- R3: Register select bit `blk*2 + d` equal to 1 makes output `d` of block `blk` come from a flip-flop. In user mode that flip-flop loads the memory value on every clock edge, so the output shows it one cycle later. When the select bit is 0, the output follows the memory combinationally.
- R4: While `cfg_en` is 1, no user flip-flop changes, even when the inputs change.
- R5: A synchronous `rst` clears every user flip-flop to 0 and leaves the configuration image as it was.
- R6: The route inputs, in index order 0 to 3, are first-block output 0, first-block output 1, `aux_in[0]` and `aux_in[1]`. Each `route_out` bit shows the input whose index its 2-bit select holds.
- R7: `route_out[0]` and `route_out[1]` are address bits 0 and 1 of the second block. Its address bit 2 is constant 0, so memory entries 4 to 7 of that block never reach `blk1_out`.
- R8: Memory word 0x6161 in the first block, with both outputs bypassed, makes output 0 equal to 1 exactly when `usr_in[1]` equals `usr_in[0]` (addresses 0, 3, 4 and 7). It makes output 1 equal to `usr_in[1] & ~usr_in[0]`.
- R9: Memory word 0x1B1B with both outputs registered turns the first block into registered inverters, `blk0_out[0] = ~usr_in[0]` and `blk0_out[1] = ~usr_in[1]`, each one cycle late. Routing these outputs into a second block set as a pass-through gives the same values on `blk1_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain and the user flip-flops |
| rst | input | 1 | Synchronous active-high clear of the user flip-flops |
| cfg_en | input | 1 | 1 selects configuration mode: the image shifts and user flip-flops hold |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| usr_in | input | 3 | Address inputs of the first block |
| aux_in | input | 2 | Route inputs 2 and 3 |
| blk0_out | output | 2 | First block outputs, after the register-or-bypass choice |
| route_out | output | 2 | Routing stage outputs, which drive the second block's address |
| blk1_out | output | 2 | Second block outputs, after the register-or-bypass choice |

## Verification
The bench first programs a comparator and then the registered inverter circuit. It compares every output against a model of the tile's behaviour, over a full address sweep and random input patterns.

The bench reloads the configuration while the inputs change. A design that let its flip-flops load during shifting would show the new inverted value instead of the held one. It pulses reset with a live configuration. A design that cleared the image as well would lose its function after the pulse.

It steps through every route select pair. A wrong input order or swapped select fields would route the wrong signal. It also programs ones into the upper half of the second memory. A design that left the second block's top address bit floating or connected would leak those ones onto `blk1_out`.

// File: rtl/lgt_pkg.sv
package lgt_pkg;

    localparam int LUT_IN    = 3;
    localparam int LUT_OUT   = 2;
    localparam int LUT_DEPTH = 1 << LUT_IN;
    localparam int LUT_BITS  = LUT_DEPTH * LUT_OUT;
    localparam int NUM_BLK   = 2;
    localparam int SM_IN     = 4;
    localparam int SM_OUT    = 2;
    localparam int SEL_W     = $clog2(SM_IN);
    localparam int AUX_W     = SM_IN - LUT_OUT;
    localparam int RS_BITS   = NUM_BLK * LUT_OUT;
    localparam int SW_BITS   = SM_OUT * SEL_W;
    localparam int CFG_BITS  = NUM_BLK * LUT_BITS + RS_BITS + SW_BITS;

    // Packed overlay of the serial image: the first member is most significant.
    typedef struct packed {
        logic [NUM_BLK-1:0][LUT_BITS-1:0] lut;
        logic [RS_BITS-1:0]               rsel;
        logic [SM_OUT-1:0][SEL_W-1:0]     swsel;
    } tile_cfg_t;

    function automatic logic [LUT_OUT-1:0] lut_read(
        input logic [LUT_BITS-1:0] word,
        input logic [LUT_IN-1:0]   addr
    );
        return word[int'(addr) * LUT_OUT +: LUT_OUT];
    endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain
    import lgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      shift_en,
    input  logic      din,
    output tile_cfg_t cfg
);

    logic [CFG_BITS-1:0] chain_q;

    // The chain itself is never reset: user reset must leave the image intact.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            chain_q <= {chain_q[CFG_BITS-2:0], din};
        end
    end

    assign cfg = tile_cfg_t'(chain_q);

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain_q));

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lgt_pkg::*;
#(
    parameter int N_IN   = LUT_IN,
    parameter int N_OUT  = LUT_OUT,
    parameter int W_BITS = (1 << N_IN) * N_OUT
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [N_IN-1:0]   addr,
    input  logic [W_BITS-1:0] word,
    input  logic [N_OUT-1:0]  reg_sel,
    output logic [N_OUT-1:0]  y
);

    logic [N_OUT-1:0] raw;
    logic [N_OUT-1:0] ff_q;

    always_comb begin
        raw = word[int'(addr) * N_OUT +: N_OUT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ff_q <= '0;
        end else if (!hold) begin
            ff_q <= raw;
        end
    end

    for (genvar d = 0; d < N_OUT; d++) begin : g_outsel
        assign y[d] = reg_sel[d] ? ff_q[d] : raw[d];
    end

    // R4
    hold_in_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(ff_q));

    // R3
    reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (ff_q == $past(raw)));

endmodule

// File: rtl/route_matrix.sv
module route_matrix
    import lgt_pkg::*;
#(
    parameter int N_IN  = SM_IN,
    parameter int N_OUT = SM_OUT,
    parameter int SW    = $clog2(N_IN)
)(
    input  logic [N_IN-1:0]          m,
    input  logic [N_OUT-1:0][SW-1:0] sel,
    output logic [N_OUT-1:0]         o
);

    for (genvar g = 0; g < N_OUT; g++) begin : g_mux
        assign o[g] = m[sel[g]];
    end

    // R6
    always_comb begin
        if ((&m) || !(|m)) begin
            uniform_in_chk: assert (o == {N_OUT{m[0]}});
        end
    end

endmodule

// File: rtl/logic_tile.sv
module logic_tile
    import lgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_en,
    input  logic               cfg_din,
    input  logic [LUT_IN-1:0]  usr_in,
    input  logic [AUX_W-1:0]   aux_in,
    output logic [LUT_OUT-1:0] blk0_out,
    output logic [SM_OUT-1:0]  route_out,
    output logic [LUT_OUT-1:0] blk1_out
);

    tile_cfg_t                         cfg;
    logic [NUM_BLK-1:0][LUT_IN-1:0]    blk_addr;
    logic [NUM_BLK-1:0][LUT_OUT-1:0]   blk_y;
    logic [SM_IN-1:0]                  sm_in;

    cfg_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .cfg      (cfg)
    );

    // The first block takes primary inputs; the second takes the routed pair,
    // with its spare upper address bits tied low.
    assign blk_addr[0] = usr_in;
    assign blk_addr[1] = {{(LUT_IN-SM_OUT){1'b0}}, route_out};

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        lut_cell #(
            .N_IN   (LUT_IN),
            .N_OUT  (LUT_OUT),
            .W_BITS (LUT_BITS)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .hold    (cfg_en),
            .addr    (blk_addr[b]),
            .word    (cfg.lut[b]),
            .reg_sel (cfg.rsel[b*LUT_OUT +: LUT_OUT]),
            .y       (blk_y[b])
        );
    end

    assign sm_in = {aux_in, blk_y[0]};

    route_matrix #(
        .N_IN  (SM_IN),
        .N_OUT (SM_OUT),
        .SW    (SEL_W)
    ) u_route (
        .m   (sm_in),
        .sel (cfg.swsel),
        .o   (route_out)
    );

    assign blk0_out = blk_y[0];
    assign blk1_out = blk_y[1];

    // R5
    rst_clears_reg_chk: assert property (@(posedge clk) disable iff (cfg_en)
        $past(rst) |-> ((blk0_out & cfg.rsel[LUT_OUT-1:0]) == '0));

endmodule

// File: tb/logic_tile_tb_top.sv
module logic_tile_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_en;
    logic       cfg_din;
    logic [2:0] usr_in;
    logic [1:0] aux_in;
    logic [1:0] blk0_out;
    logic [1:0] route_out;
    logic [1:0] blk1_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [39:0] dev_img = '0;
    logic [1:0]  mff0 = '0;
    logic [1:0]  mff1 = '0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    event     mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic_tile dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cfg_din   (cfg_din),
        .usr_in    (usr_in),
        .aux_in    (aux_in),
        .blk0_out  (blk0_out),
        .route_out (route_out),
        .blk1_out  (blk1_out)
    );

    // Tile model from the requirements: returns {blk1, route, blk0}.
    function automatic logic [5:0] model_out(
        input  logic [39:0] c,
        input  logic [2:0]  u,
        input  logic [1:0]  ax,
        input  logic [1:0]  f0,
        input  logic [1:0]  f1,
        output logic [1:0]  raw0,
        output logic [1:0]  raw1
    );
        logic [15:0] l0, l1;
        logic [3:0]  rs, m;
        logic [1:0]  b0, b1, r;
        int          a1;
        l0 = c[23:8];
        l1 = c[39:24];
        rs = c[7:4];
        raw0 = {l0[int'(u)*2+1], l0[int'(u)*2]};
        b0[0] = rs[0] ? f0[0] : raw0[0];
        b0[1] = rs[1] ? f0[1] : raw0[1];
        m = {ax, b0};
        r[0] = m[c[1:0]];
        r[1] = m[c[3:2]];
        a1 = int'(r);
        raw1 = {l1[a1*2+1], l1[a1*2]};
        b1[0] = rs[2] ? f1[0] : raw1[0];
        b1[1] = rs[3] ? f1[1] : raw1[1];
        return {b1, r, b0};
    endfunction

    always @(posedge clk) begin
        logic [1:0] r0, r1;
        logic [5:0] unused_o;
        if (rst) begin
            mff0 <= '0;
            mff1 <= '0;
        end else if (!cfg_en) begin
            unused_o = model_out(dev_img, usr_in, aux_in, mff0, mff1, r0, r1);
            mff0 <= r0;
            mff1 <= r1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the last shift.
    task automatic cfg_load(input logic [39:0] img);
        cfg_en = 1'b1;
        for (int i = 39; i >= 0; i--) begin
            cfg_din = img[i];
            @(negedge clk);
        end
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
        dev_img = img;
    endtask

    // Driver: applies one input pattern and queues the expected outputs.
    task automatic apply(input logic [2:0] u, input logic [1:0] ax, input string tag);
        sb_item_t   it;
        logic [1:0] r0, r1;
        @(negedge clk);
        usr_in = u;
        aux_in = ax;
        #1;
        it.exp = model_out(dev_img, u, ax, mff0, mff1, r0, r1);
        it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
    endtask

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                sb_item_t   it;
                logic [5:0] act;
                it  = sb_q.pop_front();
                act = {blk1_out, route_out, blk0_out};
                chk(act == it.exp, it.tag, {2'b0, act}, {2'b0, it.exp});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [39:0] img_xnor, img_inv, img;
        rst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0; usr_in = '0; aux_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 / R1 / R2: comparator on the low two address bits, bypassed.
        img_xnor = {16'h0000, 16'h6161, 4'b0000, 4'b0000};
        cfg_load(img_xnor);
        for (int a = 0; a < 8; a++) begin
            logic [2:0] av;
            av = 3'(a);
            @(negedge clk);
            usr_in = av;
            #1;
            chk(blk0_out[0] == (av[1] ~^ av[0]), "R8 xnor", {6'b0, blk0_out}, {7'b0, av[1] ~^ av[0]});
            chk(blk0_out[1] == (av[1] & ~av[0]), "R2 second function", {6'b0, blk0_out}, {7'b0, av[1] & ~av[0]});
        end

        // R9 / R3: registered inverters routed into a pass-through second block.
        img_inv = {16'hE4E4, 16'h1B1B, 4'b0011, 2'b01, 2'b00};
        cfg_load(img_inv);
        for (int i = 0; i < 40; i++) begin
            apply(3'($urandom), 2'($urandom), "R9 registered inverters");
        end
        apply(3'b010, 2'b00, "R3 load");
        @(negedge clk);
        #1;
        chk(blk0_out == 2'b01, "R3 one cycle later", {6'b0, blk0_out}, 8'h01);
        chk(blk1_out == 2'b01, "R9 through route", {6'b0, blk1_out}, 8'h01);

        // R4: inputs change while the same image is reloaded; flops hold.
        usr_in = 3'b000;
        @(negedge clk);
        usr_in = 3'b011;
        cfg_load(img_inv);
        #1;
        chk(blk0_out == 2'b11, "R4 hold during config", {6'b0, blk0_out}, 8'h03);
        @(negedge clk);
        #1;
        chk(blk0_out == 2'b00, "R3 resumes after config", {6'b0, blk0_out}, 8'h00);

        // R5: reset clears the flops, image survives.
        usr_in = 3'b000;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(blk0_out == 2'b00, "R5 reset clears flops", {6'b0, blk0_out}, 8'h00);
        apply(3'b000, 2'b00, "R5 after reset");
        apply(3'b001, 2'b00, "R5 image kept");
        @(negedge clk);
        #1;
        chk(blk0_out == 2'b10, "R5 image kept", {6'b0, blk0_out}, 8'h02);

        // R6: every select pair, bypassed first block.
        for (int s = 0; s < 16; s++) begin
            img = {16'hE4E4, 16'h9C35, 4'b0000, 4'(s)};
            cfg_load(img);
            for (int i = 0; i < 6; i++) begin
                apply(3'($urandom), 2'($urandom), "R6 route select");
            end
        end
        img = {16'hE4E4, 16'h9C35, 4'b0000, 2'b11, 2'b10};
        cfg_load(img);
        aux_in = 2'b10;
        #1;
        chk(route_out == 2'b10, "R6 aux to route", {6'b0, route_out}, 8'h02);

        // R7: upper half of the second memory must never reach its outputs.
        img = {16'hFF00, 16'h6161, 4'b0000, 2'b11, 2'b10};
        cfg_load(img);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            usr_in = 3'($urandom);
            aux_in = 2'(i);
            #1;
            chk(blk1_out == 2'b00, "R7 top address tied low", {6'b0, blk1_out}, 8'h00);
        end
        for (int i = 0; i < 8; i++) begin
            apply(3'($urandom), 2'($urandom), "R7 model");
        end

        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule